// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns 32-bit linear addresses into physical addresses for 4 KiB pages. A request carries the linear address and the access kind: read or write, and user or supervisor. When paging is enabled, the block reads a page-directory entry through a single memory read port. It then reads a page-table entry from the table that the directory entry names. The physical frame comes from the page-table entry, and the low 12 bits pass through unchanged. Either result goes back as a one-cycle response: a physical address, or a page fault with a reason code and the faulting linear address.

Successful translations are kept in a small fully associative translation cache. Each cached entry holds the combined write and user rights of both levels. A later access to the same page is answered one cycle after it is accepted, with no memory traffic. Software points the walker at a new page directory by loading the base register, and that load also empties the cache. Software reloads the base after it edits directory or table entries. Only one request is in flight at a time.

Top module: `pgwalk_top`

## Requirements
- R1: With `paging_en` low, an accepted request returns `rsp_phys` equal to `req_lin` with no fault, one cycle after acceptance, and issues no memory read.
- R2: With paging enabled, the directory entry is read at {base[31:12], lin[31:22], 2'b00}. The table entry is read at {dir_entry[31:12], lin[21:12], 2'b00}. The result is {table_entry[31:12], lin[11:0]}.
- R3: Entry bit 0 is present. A clear present bit at either level faults with code bit 0 = 0. A non-present directory entry ends the walk after one read.
- R4: A write to a page whose writable bit (entry bit 1) is clear at either level faults with code bit 0 = 1.
- R5: A user access (`req_user`=1) to a page whose user bit (entry bit 2) is clear at either level faults with code bit 0 = 1. A directory-level denial ends the walk after one read.
- R6: On a fault, `rsp_fault_code` bit 1 equals `req_write`, bit 2 equals `req_user`, `rsp_fault_addr` equals the linear address, and `rsp_phys` is zero.
- R7: A request to a page translated earlier and still cached is answered one cycle after acceptance with no memory read.
- R8: A cache hit still enforces the cached write and user rights, and faults as a protection violation without a memory read.
- R9: A `base_load` pulse empties the cache, so the next request to any page walks memory again.
- R10: A `base_load` during a walk keeps that walk's result out of the cache.
- R11: While `mem_rd_valid` is high and `mem_rd_ack` is low, the read request and its address stay unchanged.
- R12: A translation that faults is not cached, and repeating it walks memory again.
- R13: With TLB_ENTRIES entries, filling TLB_ENTRIES+1 distinct pages after a flush evicts the first page filled, while the second stays cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Enables translation; when low, addresses pass through |
| base_load | input | 1 | Loads the directory base register and empties the cache |
| base_addr | input | 32 | New directory base; bits [31:12] are kept |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_phys | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Page fault flag |
| rsp_fault_code | output | 3 | Bit 0 protection (1) vs not-present (0), bit 1 write, bit 2 user |
| rsp_fault_addr | output | 32 | Faulting linear address |
| mem_rd_valid | output | 1 | Entry read request, held until acknowledged |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry returned by memory |

## Verification
The embedded properties check on every cycle that a pending read holds its address and that pass-through mode never touches memory. They also check that a non-present directory entry ends the walk with a not-present fault, that a faulting response carries a zero address, that no two cache entries match one page, and that a flush leaves no valid entry. Other behaviour only shows over a sequence of requests: fault codes at each level, cache reuse and eviction order, flushing on a base reload, and keeping a walk's result out of the cache after a reload during that walk. The bench's directed scenarios and a random sweep over pages with random rights show these.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   // entry bit positions
   localparam int unsigned ENT_P = 0;
   localparam int unsigned ENT_W = 1;
   localparam int unsigned ENT_U = 2;

   // fault code bit positions
   localparam int unsigned FC_PROT = 0;
   localparam int unsigned FC_WR   = 1;
   localparam int unsigned FC_USR  = 2;

   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_DIR  = 2'd1,
      WK_TBL  = 2'd2
   } walk_state_t;

   function automatic logic access_denied(input logic wr_ok, input logic usr_ok,
                                          input logic is_wr, input logic is_usr);
      return (is_wr && !wr_ok) || (is_usr && !usr_ok);
   endfunction

   function automatic logic [2:0] fault_code(input logic is_usr, input logic is_wr,
                                             input logic prot);
      logic [2:0] c;
      c = '0;
      c[FC_PROT] = prot;
      c[FC_WR]   = is_wr;
      c[FC_USR]  = is_usr;
      return c;
   endfunction

endpackage

// File: rtl/pgw_tlb.sv
module pgw_tlb #(
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PFN_W   = 20,
   parameter int unsigned ENTRIES = 4,
   localparam int unsigned PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   output logic             lk_w,
   output logic             lk_u,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic             fill_w,
   input  logic             fill_u
);

   logic [ENTRIES-1:0] vld;
   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] w_q;
   logic [ENTRIES-1:0] u_q;
   logic [VPN_W-1:0]   tag_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q [ENTRIES];
   logic [PTR_W-1:0]   ptr;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hit_vec[i] = vld[i] && (tag_q[i] == lk_vpn);
   end

   assign lk_hit = |hit_vec;

   always_comb begin
      lk_pfn = '0;
      lk_w   = 1'b0;
      lk_u   = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            lk_pfn = lk_pfn | pfn_q[i];
            lk_w   = lk_w | w_q[i];
            lk_u   = lk_u | u_q[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
         ptr <= '0;
      end else if (flush) begin
         vld <= '0;
      end else if (fill_en) begin
         vld[ptr] <= 1'b1;
         ptr      <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en && !flush) begin
         tag_q[ptr] <= fill_vpn;
         pfn_q[ptr] <= fill_pfn;
         w_q[ptr]   <= fill_w;
         u_q[ptr]   <= fill_u;
      end
   end

   // R7
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R9
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld == '0));

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
   import pgw_pkg::*;
#(
   parameter int unsigned LIN_W     = 32,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned IDX_W     = 10,
   localparam int unsigned PFN_W    = LIN_W - PAGE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             paging_en,
   input  logic             base_load,
   input  logic [PFN_W-1:0] base_pfn_nxt,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [LIN_W-1:0] req_lin,
   input  logic             req_write,
   input  logic             req_user,
   input  logic             hit,
   input  logic [PFN_W-1:0] hit_pfn,
   input  logic             hit_w,
   input  logic             hit_u,
   output logic             fill_en,
   output logic [PFN_W-1:0] fill_vpn,
   output logic [PFN_W-1:0] fill_pfn,
   output logic             fill_w,
   output logic             fill_u,
   output logic             mem_rd_valid,
   output logic [LIN_W-1:0] mem_rd_addr,
   input  logic             mem_rd_ack,
   input  logic [LIN_W-1:0] mem_rd_data,
   output logic             rsp_valid,
   output logic [LIN_W-1:0] rsp_phys,
   output logic             rsp_fault,
   output logic [2:0]       rsp_fault_code,
   output logic [LIN_W-1:0] rsp_fault_addr
);

   walk_state_t      st;
   logic [LIN_W-1:0] cur_lin;
   logic             cur_wr;
   logic             cur_usr;
   logic [PFN_W-1:0] cur_base;
   logic [PFN_W-1:0] tbl_pfn;
   logic             tbl_w;
   logic             tbl_u;
   logic             stale;

   logic             ent_p;
   logic             ent_w;
   logic             ent_u;
   logic             ent_denied;
   logic [PFN_W-1:0] ent_pfn;
   logic [IDX_W-1:0] dir_idx;
   logic [IDX_W-1:0] tbl_idx;
   logic             unused_entbits;

   assign ent_p      = mem_rd_data[ENT_P];
   assign ent_w      = mem_rd_data[ENT_W];
   assign ent_u      = mem_rd_data[ENT_U];
   assign ent_pfn    = mem_rd_data[LIN_W-1:PAGE_BITS];
   assign ent_denied = access_denied(ent_w, ent_u, cur_wr, cur_usr);
   assign unused_entbits = ^mem_rd_data[PAGE_BITS-1:3];

   assign dir_idx = cur_lin[LIN_W-1 -: IDX_W];
   assign tbl_idx = cur_lin[PAGE_BITS+IDX_W-1 -: IDX_W];

   assign req_ready    = (st == WK_IDLE);
   assign mem_rd_valid = (st == WK_DIR) || (st == WK_TBL);
   assign mem_rd_addr  = (st == WK_DIR) ? {cur_base, dir_idx, 2'b00}
                                        : {tbl_pfn, tbl_idx, 2'b00};

   assign fill_en  = (st == WK_TBL) && mem_rd_ack && ent_p && !ent_denied
                     && !stale && !base_load;
   assign fill_vpn = cur_lin[LIN_W-1:PAGE_BITS];
   assign fill_pfn = ent_pfn;
   assign fill_w   = tbl_w & ent_w;
   assign fill_u   = tbl_u & ent_u;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st             <= WK_IDLE;
         cur_lin        <= '0;
         cur_wr         <= 1'b0;
         cur_usr        <= 1'b0;
         cur_base       <= '0;
         tbl_pfn        <= '0;
         tbl_w          <= 1'b0;
         tbl_u          <= 1'b0;
         stale          <= 1'b0;
         rsp_valid      <= 1'b0;
         rsp_phys       <= '0;
         rsp_fault      <= 1'b0;
         rsp_fault_code <= '0;
         rsp_fault_addr <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (base_load && st != WK_IDLE) stale <= 1'b1;
         case (st)
            WK_IDLE: begin
               if (req_valid) begin
                  cur_lin  <= req_lin;
                  cur_wr   <= req_write;
                  cur_usr  <= req_user;
                  cur_base <= base_pfn_nxt;
                  stale    <= 1'b0;
                  if (!paging_en) begin
                     rsp_valid      <= 1'b1;
                     rsp_phys       <= req_lin;
                     rsp_fault      <= 1'b0;
                     rsp_fault_code <= '0;
                     rsp_fault_addr <= '0;
                  end else if (hit && !base_load) begin
                     rsp_valid <= 1'b1;
                     if (access_denied(hit_w, hit_u, req_write, req_user)) begin
                        rsp_phys       <= '0;
                        rsp_fault      <= 1'b1;
                        rsp_fault_code <= fault_code(req_user, req_write, 1'b1);
                        rsp_fault_addr <= req_lin;
                     end else begin
                        rsp_phys       <= {hit_pfn, req_lin[PAGE_BITS-1:0]};
                        rsp_fault      <= 1'b0;
                        rsp_fault_code <= '0;
                        rsp_fault_addr <= '0;
                     end
                  end else begin
                     st <= WK_DIR;
                  end
               end
            end
            WK_DIR: begin
               if (mem_rd_ack) begin
                  if (!ent_p || ent_denied) begin
                     rsp_valid      <= 1'b1;
                     rsp_phys       <= '0;
                     rsp_fault      <= 1'b1;
                     rsp_fault_code <= fault_code(cur_usr, cur_wr, ent_p);
                     rsp_fault_addr <= cur_lin;
                     st             <= WK_IDLE;
                  end else begin
                     tbl_pfn <= ent_pfn;
                     tbl_w   <= ent_w;
                     tbl_u   <= ent_u;
                     st      <= WK_TBL;
                  end
               end
            end
            WK_TBL: begin
               if (mem_rd_ack) begin
                  rsp_valid <= 1'b1;
                  st        <= WK_IDLE;
                  if (!ent_p || ent_denied) begin
                     rsp_phys       <= '0;
                     rsp_fault      <= 1'b1;
                     rsp_fault_code <= fault_code(cur_usr, cur_wr, ent_p);
                     rsp_fault_addr <= cur_lin;
                  end else begin
                     rsp_phys       <= {ent_pfn, cur_lin[PAGE_BITS-1:0]};
                     rsp_fault      <= 1'b0;
                     rsp_fault_code <= '0;
                     rsp_fault_addr <= '0;
                  end
               end
            end
            default: st <= WK_IDLE;
         endcase
      end
   end

   // R11
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   // R1
   bypass_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && !paging_en) |=>
         (!mem_rd_valid && rsp_valid && !rsp_fault && rsp_phys == $past(req_lin)));

   // R6
   fault_phys_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_phys == '0));

   // R3
   dir_absent_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WK_DIR && mem_rd_ack && !mem_rd_data[ENT_P]) |=>
         (req_ready && rsp_valid && rsp_fault && !rsp_fault_code[FC_PROT]));

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
   parameter int unsigned LIN_W       = 32,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned IDX_W       = 10,
   parameter int unsigned TLB_ENTRIES = 4,
   localparam int unsigned PFN_W      = LIN_W - PAGE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             paging_en,
   input  logic             base_load,
   input  logic [LIN_W-1:0] base_addr,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [LIN_W-1:0] req_lin,
   input  logic             req_write,
   input  logic             req_user,
   output logic             rsp_valid,
   output logic [LIN_W-1:0] rsp_phys,
   output logic             rsp_fault,
   output logic [2:0]       rsp_fault_code,
   output logic [LIN_W-1:0] rsp_fault_addr,
   output logic             mem_rd_valid,
   output logic [LIN_W-1:0] mem_rd_addr,
   input  logic             mem_rd_ack,
   input  logic [LIN_W-1:0] mem_rd_data
);

   if (LIN_W != PAGE_BITS + 2 * IDX_W || PAGE_BITS != IDX_W + 2) begin : g_bad_geom
      $error("pgwalk_top: address split must give two equal index fields of 4-byte entries");
   end

   logic [PFN_W-1:0] base_pfn;
   logic [PFN_W-1:0] base_pfn_nxt;
   logic             unused_base_low;

   logic             hit;
   logic [PFN_W-1:0] hit_pfn;
   logic             hit_w;
   logic             hit_u;
   logic             fill_en;
   logic [PFN_W-1:0] fill_vpn;
   logic [PFN_W-1:0] fill_pfn;
   logic             fill_w;
   logic             fill_u;

   assign unused_base_low = ^base_addr[PAGE_BITS-1:0];
   assign base_pfn_nxt    = base_load ? base_addr[LIN_W-1:PAGE_BITS] : base_pfn;

   always_ff @(posedge clk) begin
      if (!rst_n) base_pfn <= '0;
      else        base_pfn <= base_pfn_nxt;
   end

   if (TLB_ENTRIES > 0) begin : g_cache
      pgw_tlb #(
         .VPN_W   (PFN_W),
         .PFN_W   (PFN_W),
         .ENTRIES (TLB_ENTRIES)
      ) u_tlb (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (base_load),
         .lk_vpn   (req_lin[LIN_W-1:PAGE_BITS]),
         .lk_hit   (hit),
         .lk_pfn   (hit_pfn),
         .lk_w     (hit_w),
         .lk_u     (hit_u),
         .fill_en  (fill_en),
         .fill_vpn (fill_vpn),
         .fill_pfn (fill_pfn),
         .fill_w   (fill_w),
         .fill_u   (fill_u)
      );
   end else begin : g_nocache
      assign hit     = 1'b0;
      assign hit_pfn = '0;
      assign hit_w   = 1'b0;
      assign hit_u   = 1'b0;
   end

   pgw_walker #(
      .LIN_W     (LIN_W),
      .PAGE_BITS (PAGE_BITS),
      .IDX_W     (IDX_W)
   ) u_walk (
      .clk            (clk),
      .rst_n          (rst_n),
      .paging_en      (paging_en),
      .base_load      (base_load),
      .base_pfn_nxt   (base_pfn_nxt),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_lin        (req_lin),
      .req_write      (req_write),
      .req_user       (req_user),
      .hit            (hit),
      .hit_pfn        (hit_pfn),
      .hit_w          (hit_w),
      .hit_u          (hit_u),
      .fill_en        (fill_en),
      .fill_vpn       (fill_vpn),
      .fill_pfn       (fill_pfn),
      .fill_w         (fill_w),
      .fill_u         (fill_u),
      .mem_rd_valid   (mem_rd_valid),
      .mem_rd_addr    (mem_rd_addr),
      .mem_rd_ack     (mem_rd_ack),
      .mem_rd_data    (mem_rd_data),
      .rsp_valid      (rsp_valid),
      .rsp_phys       (rsp_phys),
      .rsp_fault      (rsp_fault),
      .rsp_fault_code (rsp_fault_code),
      .rsp_fault_addr (rsp_fault_addr)
   );

endmodule

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;

   localparam int CLK_NS = 10;
   localparam logic [31:0] DIR_BASE = 32'h0010_0000;
   localparam logic [31:0] TBL_A    = 32'h0020_0000;
   localparam logic [31:0] TBL_B    = 32'h0030_0000;
   localparam logic [31:0] TBL_R    = 32'h0040_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        paging_en = 1'b0;
   logic        base_load = 1'b0;
   logic [31:0] base_addr = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_lin = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_phys;
   logic        rsp_fault;
   logic [2:0]  rsp_fault_code;
   logic [31:0] rsp_fault_addr;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_ack = 1'b0;
   logic [31:0] mem_rd_data = '0;

   logic [31:0] pmem [logic [31:0]];
   int          n_reads = 0;
   int          wait_cnt = 0;
   int          n_cmp = 0;
   int          n_bad = 0;
   logic [31:0] g_phys, g_faddr;
   logic        g_flt;
   logic [2:0]  g_code;
   int          g_lat, g_rd;

   always #(CLK_NS/2) clk = ~clk;

   pgwalk_top u0 (
      .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .base_load(base_load),
      .base_addr(base_addr), .req_valid(req_valid), .req_ready(req_ready),
      .req_lin(req_lin), .req_write(req_write), .req_user(req_user),
      .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_fault(rsp_fault),
      .rsp_fault_code(rsp_fault_code), .rsp_fault_addr(rsp_fault_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
   );

   function automatic logic [31:0] rd(input logic [31:0] a);
      return pmem.exists(a) ? pmem[a] : 32'h0;
   endfunction

   function automatic logic [31:0] ent(input logic [19:0] fr, input bit u, input bit w, input bit p);
      return {fr, 9'h0, u, w, p};
   endfunction

   function automatic logic [31:0] lin_of(input int d, input int t, input logic [11:0] off);
      return {d[9:0], t[9:0], off};
   endfunction

   // memory model: acknowledges each entry read after 0..2 extra cycles
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rd_ack <= 1'b0;
         wait_cnt   <= 0;
      end else if (mem_rd_valid && !mem_rd_ack) begin
         if (wait_cnt == 0) begin
            mem_rd_ack  <= 1'b1;
            mem_rd_data <= rd(mem_rd_addr);
            n_reads     <= n_reads + 1;
            wait_cnt    <= int'($urandom % 3);
         end else begin
            wait_cnt <= wait_cnt - 1;
         end
      end else begin
         mem_rd_ack <= 1'b0;
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   function automatic void model(input logic [31:0] lin, input bit wr, input bit usr,
                                 input bit pg, input logic [31:0] base,
                                 output logic [31:0] ph, output bit flt, output logic [2:0] code);
      logic [31:0] pde, pte;
      ph = 32'h0; flt = 1'b1; code = {usr, wr, 1'b0};
      if (!pg) begin ph = lin; flt = 1'b0; code = 3'b000; return; end
      pde = rd({base[31:12], lin[31:22], 2'b00});
      if (!pde[0]) return;
      if ((wr && !pde[1]) || (usr && !pde[2])) begin code[0] = 1'b1; return; end
      pte = rd({pde[31:12], lin[21:12], 2'b00});
      if (!pte[0]) return;
      if ((wr && !pte[1]) || (usr && !pte[2])) begin code[0] = 1'b1; return; end
      ph = {pte[31:12], lin[11:0]}; flt = 1'b0; code = 3'b000;
   endfunction

   task automatic do_base(input logic [31:0] a);
      @(negedge clk);
      base_load = 1'b1; base_addr = a;
      @(negedge clk);
      base_load = 1'b0;
   endtask

   task automatic do_req(input logic [31:0] lin, input bit wr, input bit usr, input bit pulse);
      int r0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_lin = lin; req_write = wr; req_user = usr;
      r0 = n_reads;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (pulse) begin base_load = 1'b1; base_addr = DIR_BASE; end
      g_lat = 1;
      while (!rsp_valid && g_lat < 60) begin
         @(negedge clk);
         base_load = 1'b0;
         g_lat++;
      end
      base_load = 1'b0;
      g_phys = rsp_phys; g_flt = rsp_fault; g_code = rsp_fault_code; g_faddr = rsp_fault_addr;
      g_rd = n_reads - r0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] eph;
      bit          eflt;
      logic [2:0]  ecode;
      void'($urandom(32'd4242));

      // directory at DIR_BASE: dir1 -> TBL_A (rw, user), dir2 -> TBL_B (supervisor only)
      pmem[DIR_BASE + 4]  = ent(TBL_A[31:12], 1, 1, 1);
      pmem[DIR_BASE + 8]  = ent(TBL_B[31:12], 0, 1, 1);
      pmem[TBL_A + 2*4]   = ent(20'hABCDE, 1, 1, 1);
      pmem[TBL_A + 3*4]   = ent(20'h11111, 1, 0, 1);
      pmem[TBL_A + 4*4]   = ent(20'h22222, 1, 0, 1);
      pmem[TBL_A + 6*4]   = ent(20'h66666, 1, 1, 1);
      pmem[TBL_B + 0]     = ent(20'h33333, 1, 1, 1);
      for (int i = 10; i < 15; i++) pmem[TBL_A + 32'(i*4)] = ent(20'h70000 + 20'(i), 1, 1, 1);

      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset req_ready", {31'h0, req_ready}, 32'h1);
      chk("reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
      chk("reset mem_rd_valid", {31'h0, mem_rd_valid}, 32'h0);

      // R1 pass-through
      do_req(32'h1234_5678, 1, 1, 0);
      chk("R1 phys", g_phys, 32'h1234_5678);
      chk("R1 fault", {31'h0, g_flt}, 32'h0);
      chk("R1 reads", 32'(g_rd), 32'h0);
      chk("R1 latency", 32'(g_lat), 32'h1);

      paging_en = 1'b1;
      do_base(DIR_BASE);

      // R2 full walk
      do_req(lin_of(1, 2, 12'h345), 1, 1, 0);
      chk("R2 phys", g_phys, 32'hABCD_E345);
      chk("R2 reads", 32'(g_rd), 32'h2);
      // R7 cached
      do_req(lin_of(1, 2, 12'h004), 0, 1, 0);
      chk("R7 phys", g_phys, 32'hABCD_E004);
      chk("R7 reads", 32'(g_rd), 32'h0);
      chk("R7 latency", 32'(g_lat), 32'h1);

      // R8 cached rights still enforced
      do_req(lin_of(1, 3, 12'h010), 0, 1, 0);
      chk("R8 fill phys", g_phys, 32'h1111_1010);
      do_req(lin_of(1, 3, 12'h020), 1, 0, 0);
      chk("R8 fault", {31'h0, g_flt}, 32'h1);
      chk("R8 code", {29'h0, g_code}, 32'h3);
      chk("R8 reads", 32'(g_rd), 32'h0);
      chk("R6 fault addr", g_faddr, lin_of(1, 3, 12'h020));
      chk("R6 phys zero", g_phys, 32'h0);

      // R4 write to read-only table entry, uncached
      do_req(lin_of(1, 4, 12'h0), 1, 1, 0);
      chk("R4 code", {29'h0, g_code}, 32'h7);
      chk("R4 reads", 32'(g_rd), 32'h2);
      // R12 faults not cached
      do_req(lin_of(1, 4, 12'h0), 1, 1, 0);
      chk("R12 reads", 32'(g_rd), 32'h2);

      // R5 user denied at directory level
      do_req(lin_of(2, 0, 12'h0AB), 0, 1, 0);
      chk("R5 code", {29'h0, g_code}, 32'h5);
      chk("R5 reads", 32'(g_rd), 32'h1);
      do_req(lin_of(2, 0, 12'h0AB), 1, 0, 0);
      chk("R5 supervisor phys", g_phys, 32'h3333_30AB);

      // R3 not present at each level
      do_req(lin_of(3, 0, 12'h0), 0, 0, 0);
      chk("R3 dir code", {29'h0, g_code}, 32'h0);
      chk("R3 dir fault", {31'h0, g_flt}, 32'h1);
      chk("R3 dir reads", 32'(g_rd), 32'h1);
      do_req(lin_of(1, 5, 12'h0), 1, 1, 0);
      chk("R3 tbl code", {29'h0, g_code}, 32'h6);
      chk("R3 tbl reads", 32'(g_rd), 32'h2);

      // R9 reload flushes
      pmem[TBL_A + 2*4] = ent(20'h55555, 1, 1, 1);
      do_req(lin_of(1, 2, 12'h001), 0, 0, 0);
      chk("R9 stale hit phys", g_phys, 32'hABCD_E001);
      do_base(DIR_BASE);
      do_req(lin_of(1, 2, 12'h001), 0, 0, 0);
      chk("R9 phys after flush", g_phys, 32'h5555_5001);
      chk("R9 reads", 32'(g_rd), 32'h2);

      // R10 reload during walk
      do_req(lin_of(1, 6, 12'h007), 0, 0, 1);
      chk("R10 phys", g_phys, 32'h6666_6007);
      do_req(lin_of(1, 6, 12'h008), 0, 0, 0);
      chk("R10 reads", 32'(g_rd), 32'h2);

      // R13 replacement order
      do_base(DIR_BASE);
      for (int i = 10; i < 15; i++) do_req(lin_of(1, i, 12'h0), 0, 0, 0);
      do_req(lin_of(1, 11, 12'h0), 0, 0, 0);
      chk("R13 second kept", 32'(g_rd), 32'h0);
      do_req(lin_of(1, 10, 12'h0), 0, 0, 0);
      chk("R13 first evicted", 32'(g_rd), 32'h2);

      // random sweep over pages with random rights
      for (int d = 8; d < 12; d++) begin
         pmem[DIR_BASE + 32'(d*4)] = ent(TBL_R[31:12] + 20'(d), ($urandom % 4) != 0,
                                         ($urandom % 4) != 0, ($urandom % 6) != 0);
         for (int t = 0; t < 8; t++)
            pmem[TBL_R + 32'(d*4096) + 32'(t*4)] = ent(20'($urandom), $urandom % 2,
                                                       $urandom % 2, ($urandom % 5) != 0);
      end
      do_base(DIR_BASE);
      for (int k = 0; k < 300; k++) begin
         logic [31:0] l;
         bit wr, usr;
         l   = lin_of(8 + int'($urandom % 4), int'($urandom % 8), 12'($urandom));
         wr  = $urandom % 2;
         usr = $urandom % 2;
         paging_en = ($urandom % 8) != 0;
         model(l, wr, usr, paging_en, DIR_BASE, eph, eflt, ecode);
         do_req(l, wr, usr, 0);
         chk("R2 random phys", g_phys, eph);
         chk("R6 random fault", {31'h0, g_flt}, {31'h0, eflt});
         if (eflt) begin
            chk("R6 random code", {29'h0, g_code}, {29'h0, ecode});
            chk("R6 random addr", g_faddr, l);
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule